// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block turns two external interrupt pins into pending-interrupt flags and request lines for a vectoring unit. Each pin is first brought into the clock domain through a two-stage synchronizer. A per-input sense mode then picks what counts as an event: a low level, any change of logic value, a falling edge or a rising edge. A detected edge or change sets that input's flag. In low-level mode the flag is never used. The request follows the synchronized pin instead.

Software reads the flags through a byte-wide register on a simple register bus at offset 0x028. It clears a flag by writing a one to that flag's bit. The vectoring unit clears a flag with a one-cycle acknowledge pulse when it services the interrupt. A flag drives its request line only when that input's mask bit and the global interrupt enable are both set. The sense modes, mask bits and global enable arrive as inputs from neighbouring configuration logic.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, both flags are 0. A read at offset 0x028 returns 0x00 and both request lines are low.
- R2: In rising-edge mode (code 2'b11), a 0-to-1 change of the pin sets the input's flag, which is visible on the third clock edge after the pin changes. A 1-to-0 change does not set it.
- R3: In falling-edge mode (code 2'b10), a 1-to-0 change sets the flag. A 0-to-1 change does not.
- R4: In any-change mode (code 2'b01), every change of the pin in either direction sets the flag.
- R5: Outside level mode, request bit i is high exactly when flag i, mask bit i and the global enable are all 1.
- R6: A one-cycle acknowledge pulse on ack bit i clears flag i at the next clock edge.
- R7: Bit 0 of the register at 0x028 is the flag of input 0 and bit 1 is the flag of input 1. Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. Bits 7..2 read as 0 and ignore writes. Reads at any other offset return 0.
- R8: In low-level mode (code 2'b00), the input's flag is forced to 0 and stays 0. Its request is high while the synchronized pin is low, the mask bit is 1 and the global enable is 1.
- R9: When an event and a clear (acknowledge or write-one) reach the same flag in the same cycle, the flag ends up set.
- R10: Changing an input's sense mode never sets its flag by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 2 | Asynchronous external interrupt pins |
| sense_mode_i | input | 4 | Two-bit sense code per input; bits [1:0] are input 0 |
| irq_mask_i | input | 2 | Per-input request enable |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 2 | One-cycle service acknowledge per input |
| bus_addr_i | input | 12 | Register bus address |
| bus_we_i | input | 1 | Register bus write strobe |
| bus_wdata_i | input | 8 | Register bus write data |
| bus_rdata_o | output | 8 | Register bus read data |
| irq_req_o | output | 2 | Request lines to the vectoring unit |

## Verification
The pins are driven through rises and falls under each of the four sense codes. This separates edge polarity, any-change and level behaviour, and shows that an edge of the wrong direction leaves the flag alone. Clears are applied by acknowledge and by write-one. One write carries zeros in the flag bits and ones in the reserved bits, which shows that only a one clears and that reserved bits cannot be set. Clears are also placed on the same cycle as a fresh event to confirm that the set wins. Mode switches are made with the pin held steady to confirm that no event appears.

// File: rtl/extint_pkg.sv
// Package: shared types and constants for the external interrupt controller.
// Assumes: sense codes are fixed by the neighbouring configuration logic.
package extint_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam int REG_W = 8;

endpackage

// File: rtl/extint_detect.sv
// Module: extint_detect
// Synchronizes one external pin through SYNC_STAGES flops and reports a
// one-cycle event when the selected edge or change appears.
// Assumes: pin_i is asynchronous; mode_i is quasi-static. Any change of
// mode_i suppresses detection for that cycle. The previous-sample register
// follows the synchronized pin every cycle, so a mode switch cannot fake an edge.
module extint_detect
    import extint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_i,
    input  sense_e mode_i,
    output logic   pin_sync_o,
    output logic   evt_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    sense_e                 mode_q;
    logic                   mode_chg;
    logic                   cur;

    assign cur        = sync_q[SYNC_STAGES-1];
    assign pin_sync_o = cur;
    assign mode_chg   = (mode_i != mode_q);

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    // Keep the previous synchronized sample and the last seen mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            mode_q <= mode_i;
        end else begin
            prev_q <= cur;
            mode_q <= mode_i;
        end
    end

    // Decide whether this cycle holds an event for the selected mode.
    always_comb begin
        evt_o = 1'b0;
        if (!mode_chg) begin
            unique case (mode_i)
                SENSE_LOW:  evt_o = 1'b0;
                SENSE_ANY:  evt_o = cur ^ prev_q;
                SENSE_FALL: evt_o = prev_q & ~cur;
                SENSE_RISE: evt_o = cur & ~prev_q;
                default:    evt_o = 1'b0;
            endcase
        end
    end

    AST_LEVEL_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SENSE_LOW) |-> !evt_o); // R8
    AST_RISE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && mode_i == SENSE_RISE) |-> (cur && !$past(cur))); // R2
    AST_FALL_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && mode_i == SENSE_FALL) |-> (!cur && $past(cur))); // R3
    AST_MODE_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != $past(mode_i)) |-> !evt_o); // R10

endmodule

// File: rtl/extint_flags.sv
// Module: extint_flags
// Holds one pending flag per input. Hold-to-zero beats everything; a set
// beats a clear so that no event is lost.
// Assumes: evt_i and clr_i are single-cycle qualified pulses.
module extint_flags #(
    parameter int N_IN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] evt_i,
    input  logic [N_IN-1:0] clr_i,
    input  logic [N_IN-1:0] hold_zero_i,
    output logic [N_IN-1:0] flag_o
);

    for (genvar i = 0; i < N_IN; i++) begin : g_flag
        // Update one flag with priority hold, set, clear.
        always_ff @(posedge clk) begin
            if (!rst_n)              flag_o[i] <= 1'b0;
            else if (hold_zero_i[i]) flag_o[i] <= 1'b0;
            else if (evt_i[i])       flag_o[i] <= 1'b1;
            else if (clr_i[i])       flag_o[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[i] && !hold_zero_i[i]) |=> flag_o[i]); // R9
        AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            hold_zero_i[i] |=> !flag_o[i]); // R8
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !evt_i[i]) |=> !flag_o[i]); // R6
    end

endmodule

// File: rtl/extint_ctrl.sv
// Module: extint_ctrl (top)
// Two-input external interrupt controller: synchronize, detect, flag, mask.
// It exposes the flag register on a simple register bus at REG_OFFSET.
// Assumes: the bus read is combinational. A write is a single-cycle bus_we_i.
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int          N_IN        = 2,
    parameter int          ADDR_W      = 12,
    parameter int          SYNC_STAGES = 2,
    parameter logic [11:0] REG_OFFSET  = 12'h028
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   ext_pin_i,
    input  logic [2*N_IN-1:0] sense_mode_i,
    input  logic [N_IN-1:0]   irq_mask_i,
    input  logic              gie_i,
    input  logic [N_IN-1:0]   irq_ack_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    output logic [N_IN-1:0]   irq_req_o
);

    localparam logic [REG_W-1:0] FLAG_MASK = REG_W'((1 << N_IN) - 1);

    logic [N_IN-1:0] pin_sync;
    logic [N_IN-1:0] evt;
    logic [N_IN-1:0] level_mode;
    logic [N_IN-1:0] sw_clr;
    logic [N_IN-1:0] flags;
    logic            hit;

    assign hit = (bus_addr_i == ADDR_W'(REG_OFFSET));

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        sense_e mode;
        assign mode          = sense_e'(sense_mode_i[2*i +: 2]);
        assign level_mode[i] = (mode == SENSE_LOW);

        extint_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (ext_pin_i[i]),
            .mode_i     (mode),
            .pin_sync_o (pin_sync[i]),
            .evt_o      (evt[i])
        );

        // Form the request from the pin in level mode, else from the flag.
        always_comb begin
            irq_req_o[i] = gie_i & irq_mask_i[i] &
                           (level_mode[i] ? ~pin_sync[i] : flags[i]);
        end

        AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req_o[i] |-> (gie_i && irq_mask_i[i])); // R5
        AST_LEVEL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            (level_mode[i] && gie_i && irq_mask_i[i]) |-> (irq_req_o[i] == !pin_sync[i])); // R8
    end

    // Decode software write-one-to-clear for the flag bits only.
    always_comb begin
        sw_clr = '0;
        if (bus_we_i && hit) sw_clr = bus_wdata_i[N_IN-1:0];
    end

    extint_flags #(.N_IN(N_IN)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .clr_i       (sw_clr | irq_ack_i),
        .hold_zero_i (level_mode),
        .flag_o      (flags)
    );

    // Return the flags at the register offset and zero elsewhere.
    always_comb begin
        bus_rdata_o = '0;
        if (hit) bus_rdata_o[N_IN-1:0] = flags;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata_o & ~FLAG_MASK) == '0); // R7
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata_o == '0)); // R7

endmodule

// File: tb/sim_extint_ctrl.sv
`timescale 1ns/1ps
module sim_extint_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  ext_pin;
    logic [3:0]  sense_mode;
    logic [1:0]  irq_mask;
    logic        gie;
    logic [1:0]  irq_ack;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [1:0]  irq_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic [1:0] req;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    extint_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_pin_i    (ext_pin),
        .sense_mode_i (sense_mode),
        .irq_mask_i   (irq_mask),
        .gie_i        (gie),
        .irq_ack_i    (irq_ack),
        .bus_addr_i   (bus_addr),
        .bus_we_i     (bus_we),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .irq_req_o    (irq_req)
    );

    // Monitor: pop expected items at the falling edge and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_tests++;
                if (bus_rdata !== e.rd || irq_req !== e.req) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h req=%b expected rdata=%h req=%b",
                             e.tag, bus_rdata, irq_req, e.rd, e.req);
                end
            end
        end
    end

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_out(string tag, logic [7:0] rd, logic [1:0] req);
        exp_t e;
        e.tag = tag; e.rd = rd; e.req = req;
        sb.push_back(e);
        wait (sb.size() == 0);
    endtask

    task automatic sw_write(logic [7:0] d);
        bus_we = 1'b1; bus_wdata = d;
        tick();
        bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic ack(logic [1:0] a);
        irq_ack = a;
        tick();
        irq_ack = 2'b00;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ext_pin = 2'b00; sense_mode = 4'b1111;
        irq_mask = 2'b11; gie = 1'b1; irq_ack = 2'b00;
        bus_addr = 12'h028; bus_we = 1'b0; bus_wdata = 8'h00;
        tick(3);
        rst_n = 1'b1;
        tick();
        expect_out("R1 reset state", 8'h00, 2'b00);

        ext_pin[0] = 1'b1; tick(2);
        expect_out("R2 rise not yet visible", 8'h00, 2'b00);
        tick();
        expect_out("R2 rise sets flag0", 8'h01, 2'b01);

        sw_write(8'h01);
        expect_out("R7 write-one clears flag0", 8'h00, 2'b00);
        ext_pin[0] = 1'b0; tick(3);
        expect_out("R2 fall ignored in rise mode", 8'h00, 2'b00);

        ext_pin[1] = 1'b1; tick(3);
        expect_out("R2 rise sets flag1", 8'h02, 2'b10);
        sw_write(8'hFC);
        expect_out("R7 zeros and reserved bits ignored", 8'h02, 2'b10);
        bus_addr = 12'h000;
        expect_out("R7 other offset reads zero", 8'h00, 2'b10);
        bus_addr = 12'h028;

        irq_mask = 2'b01;
        expect_out("R5 mask blocks request", 8'h02, 2'b00);
        irq_mask = 2'b11; gie = 1'b0;
        expect_out("R5 global enable blocks request", 8'h02, 2'b00);
        gie = 1'b1;
        expect_out("R5 request restored", 8'h02, 2'b10);

        ack(2'b10);
        expect_out("R6 ack clears flag1", 8'h00, 2'b00);

        sense_mode = 4'b1110; tick();
        ext_pin[0] = 1'b1; tick(3);
        expect_out("R3 rise ignored in fall mode", 8'h00, 2'b00);
        ext_pin[0] = 1'b0; tick(3);
        expect_out("R3 fall sets flag0", 8'h01, 2'b01);
        ack(2'b01);

        sense_mode = 4'b1101; tick();
        ext_pin[0] = 1'b1; tick(3);
        expect_out("R4 rise sets flag0 in any mode", 8'h01, 2'b01);
        ack(2'b01);
        ext_pin[0] = 1'b0; tick(3);
        expect_out("R4 fall sets flag0 in any mode", 8'h01, 2'b01);

        ext_pin[0] = 1'b1; tick(2);
        ack(2'b01);
        expect_out("R9 event beats ack", 8'h01, 2'b01);
        ext_pin[0] = 1'b0; tick(2);
        sw_write(8'h01);
        expect_out("R9 event beats write-one", 8'h01, 2'b01);
        ack(2'b01);
        expect_out("R6 ack alone clears", 8'h00, 2'b00);

        ext_pin[0] = 1'b1; tick(3);
        expect_out("R4 flag set before level switch", 8'h01, 2'b01);
        sense_mode = 4'b1100; tick();
        expect_out("R8 level mode forces flag to zero", 8'h00, 2'b00);
        ext_pin[0] = 1'b0; tick(2);
        expect_out("R8 low pin drives request", 8'h00, 2'b01);
        irq_mask = 2'b10;
        expect_out("R8 mask applies in level mode", 8'h00, 2'b00);
        irq_mask = 2'b11;
        ext_pin[0] = 1'b1; tick(2);
        expect_out("R8 high pin drops request", 8'h00, 2'b00);

        sense_mode = 4'b1111; tick(4);
        expect_out("R10 switch to rise no event", 8'h00, 2'b00);
        sense_mode = 4'b0110; tick(4);
        expect_out("R10 switch modes with pins steady", 8'h00, 2'b00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule